// File: doc/BRIEF.md
# Polled Memory-Mapped Input Port

This block lets a processor read bytes from a simple input device over the same 10-bit read/write bus that also reaches main memory. The lower half of the address space (0 to 511) belongs to memory. The block only decodes that half and raises a select output for the memory array. The upper half (512 to 1023) is I/O space. Two fixed addresses in the I/O space expose the device: a data register at 516 and a status register at 517.

On the device side, a one-cycle strobe hands over a byte. The block latches the byte and sets a ready flag. The block never notifies the processor on its own. Software polls the status register until ready is set, then reads the data register, and that read clears ready. If a second byte arrives before the first is read, the newer byte replaces the older one and a sticky overrun flag records the loss. Memory and I/O use the same read and write strobes, and there is no separate I/O select line.

Top module: `mmio_poll_port`

## Requirements
- R1: After reset, or after a reset applied mid-run, the data register reads 0x00 and the status register reads 0x00.
- R2: `mem_sel` is 1 exactly when `bus_rd` or `bus_wr` is 1 and the address is below 512. It is 0 for any I/O address and when no access is made.
- R3: A cycle with `dev_stb` high latches `dev_byte` into the data register and sets ready, which is visible from the next cycle.
- R4: A read at address 516 returns the latched byte, and on that clock edge clears ready unless a new byte arrives in the same cycle.
- R5: A read at address 517 returns ready in bit 0 and overrun in bit 1, with bits 7:2 reading zero.
- R6: A byte that arrives while ready is set, with no data read in that cycle, sets overrun and replaces the held byte.
- R7: A status read clears overrun on that edge. If an overrun event happens in the same cycle, overrun stays set.
- R8: Writes to address 516 or 517 change neither the data register, nor ready, nor overrun.
- R9: `bus_rdata` is zero for reads of unused I/O addresses, for reads of memory addresses, and whenever `bus_rd` is low.
- R10: When a data read and a device strobe fall in the same cycle, the read returns the old byte, and ready stays set with the new byte held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 10 | Processor address |
| bus_rd | input | 1 | Processor read strobe |
| bus_wr | input | 1 | Processor write strobe |
| bus_rdata | output | 8 | Read data returned by the port (combinational) |
| mem_sel | output | 1 | Select for the memory array sharing the bus |
| dev_stb | input | 1 | Device byte-valid strobe, one cycle per byte |
| dev_byte | input | 8 | Byte from the device |

## Verification
The bench builds the block with its default parameters: a 10-bit address, an 8-bit byte, data at 516 and status at 517. These defaults place both region boundaries (511/512 and 1023) and both register addresses at fixed points that the vector table can hit directly. A byte width of 8 puts the zero-filled upper status bits at the port, where the bench can check them. With these values, the bench reaches the same-cycle collisions between the device strobe and a data read or a status read, as well as the overrun sequence.

// File: rtl/mmio_port_pkg.sv
package mmio_port_pkg;

  localparam int STAT_BITS = 2;
  localparam int RDY_BIT   = 0;
  localparam int OVR_BIT   = 1;

  function automatic logic [STAT_BITS-1:0] pack_status(input logic rdy, input logic ovr);
    logic [STAT_BITS-1:0] s;
    s          = '0;
    s[RDY_BIT] = rdy;
    s[OVR_BIT] = ovr;
    return s;
  endfunction

  function automatic logic ovr_next(input logic ovr_q, input logic evt, input logic stat_rd);
    return evt | (ovr_q & ~stat_rd);
  endfunction

endpackage

// File: rtl/mmio_addr_decode.sv
module mmio_addr_decode #(
  parameter int ADDR_W    = 10,
  parameter int DATA_ADDR = 516,
  parameter int STAT_ADDR = 517
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output logic              mem_sel,
  output logic              hit_data,
  output logic              hit_stat
);
  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_ADDR);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

  logic io_half;
  assign io_half  = addr[ADDR_W-1];
  assign mem_sel  = (rd | wr) & ~io_half;
  assign hit_data = io_half & (addr == DATA_A);
  assign hit_stat = io_half & (addr == STAT_A);
endmodule

// File: rtl/mmio_rx_holding.sv
module mmio_rx_holding
  import mmio_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_stb,
  input  logic [DATA_W-1:0] dev_byte,
  input  logic              data_rd,
  input  logic              stat_rd,
  output logic [DATA_W-1:0] data_q,
  output logic              ready_q,
  output logic              overrun_q
);
  logic ovr_evt;
  assign ovr_evt = dev_stb & ready_q & ~data_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q    <= '0;
      ready_q   <= 1'b0;
      overrun_q <= 1'b0;
    end else begin
      if (dev_stb) data_q <= dev_byte;
      ready_q   <= dev_stb | (ready_q & ~data_rd);
      overrun_q <= ovr_next(overrun_q, ovr_evt, stat_rd);
    end
  end

  assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dev_stb |=> ready_q && data_q == $past(dev_byte));
  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && !dev_stb |=> !ready_q);
  assert_overrun_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dev_stb && ready_q && !data_rd |=> overrun_q);
  assert_overrun_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !(dev_stb && ready_q && !data_rd) |=> !overrun_q);
endmodule

// File: rtl/mmio_read_mux.sv
module mmio_read_mux
  import mmio_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                 rd,
  input  logic                 hit_data,
  input  logic                 hit_stat,
  input  logic [DATA_W-1:0]    data_q,
  input  logic [STAT_BITS-1:0] stat_bits,
  output logic [DATA_W-1:0]    rdata
);
  always_comb begin
    rdata = '0;
    if (rd && hit_data)      rdata = data_q;
    else if (rd && hit_stat) rdata = DATA_W'(stat_bits);
  end
endmodule

// File: rtl/mmio_poll_port.sv
module mmio_poll_port
  import mmio_port_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 8,
  parameter int DATA_ADDR = 516,
  parameter int STAT_ADDR = 517
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              mem_sel,
  input  logic              dev_stb,
  input  logic [DATA_W-1:0] dev_byte
);
  logic                 hit_data, hit_stat;
  logic                 data_rd, stat_rd;
  logic [DATA_W-1:0]    data_q;
  logic                 ready_q, overrun_q;
  logic [STAT_BITS-1:0] stat_bits;

  mmio_addr_decode #(.ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .STAT_ADDR(STAT_ADDR)) u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
    .mem_sel(mem_sel), .hit_data(hit_data), .hit_stat(hit_stat)
  );

  assign data_rd = bus_rd & hit_data;
  assign stat_rd = bus_rd & hit_stat;

  mmio_rx_holding #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .dev_stb(dev_stb), .dev_byte(dev_byte),
    .data_rd(data_rd), .stat_rd(stat_rd),
    .data_q(data_q), .ready_q(ready_q), .overrun_q(overrun_q)
  );

  assign stat_bits = pack_status(ready_q, overrun_q);

  mmio_read_mux #(.DATA_W(DATA_W)) u_mux (
    .rd(bus_rd), .hit_data(hit_data), .hit_stat(hit_stat),
    .data_q(data_q), .stat_bits(stat_bits), .rdata(bus_rdata)
  );

  assert_io_no_mem_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) && bus_addr[ADDR_W-1] |-> !mem_sel);
  assert_status_layout_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |-> bus_rdata[DATA_W-1:STAT_BITS] == '0 && bus_rdata[RDY_BIT] == ready_q);
  assert_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !bus_rd && !dev_stb |=> $stable(data_q) && $stable(ready_q));
  assert_unused_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && (hit_data || hit_stat)) |-> bus_rdata == '0);
endmodule

// File: tb/mmio_poll_port_tb.sv
module mmio_poll_port_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_rdata;
  logic       mem_sel;
  logic       dev_stb = 1'b0;
  logic [7:0] dev_byte = '0;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmio_poll_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_rdata(bus_rdata), .mem_sel(mem_sel), .dev_stb(dev_stb), .dev_byte(dev_byte)
  );

  typedef struct packed {
    logic       rd;
    logic       wr;
    logic [9:0] addr;
    logic       stb;
    logic [7:0] dbyte;
    logic [7:0] exp_rdata;
    logic       exp_mem;
    logic [3:0] req;
  } vec_t;

  // Status encoding: bit0 ready, bit1 overrun. Data at 516, status at 517.
  localparam int NV = 27;
  localparam vec_t VT [NV] = '{
    '{1'b1,1'b0,10'd517,1'b0,8'h00,8'h00,1'b0,4'd1},  // R1 status idle
    '{1'b0,1'b0,10'd517,1'b1,8'hA5,8'h00,1'b0,4'd3},  // R3 byte in
    '{1'b1,1'b0,10'd517,1'b0,8'h00,8'h01,1'b0,4'd3},  // R3 ready seen
    '{1'b1,1'b0,10'd516,1'b0,8'h00,8'hA5,1'b0,4'd4},  // R4 data read
    '{1'b1,1'b0,10'd517,1'b0,8'h00,8'h00,1'b0,4'd4},  // R4 ready cleared
    '{1'b0,1'b0,10'd0,  1'b1,8'h3C,8'h00,1'b0,4'd9},  // R9 no read
    '{1'b0,1'b0,10'd0,  1'b1,8'h7E,8'h00,1'b0,4'd6},  // R6 second byte
    '{1'b1,1'b0,10'd517,1'b0,8'h00,8'h03,1'b0,4'd6},  // R6 overrun seen
    '{1'b1,1'b0,10'd517,1'b0,8'h00,8'h01,1'b0,4'd7},  // R7 overrun cleared
    '{1'b1,1'b0,10'd516,1'b0,8'h00,8'h7E,1'b0,4'd6},  // R6 newer byte kept
    '{1'b0,1'b1,10'd516,1'b0,8'h00,8'h00,1'b0,4'd8},  // R8 write data
    '{1'b0,1'b1,10'd517,1'b0,8'h00,8'h00,1'b0,4'd8},  // R8 write status
    '{1'b1,1'b0,10'd517,1'b0,8'h00,8'h00,1'b0,4'd8},  // R8 status unchanged
    '{1'b1,1'b0,10'd516,1'b0,8'h00,8'h7E,1'b0,4'd8},  // R8 data unchanged
    '{1'b1,1'b0,10'd512,1'b0,8'h00,8'h00,1'b0,4'd9},  // R9 unused io
    '{1'b1,1'b0,10'd1023,1'b0,8'h00,8'h00,1'b0,4'd9}, // R9 top io
    '{1'b1,1'b0,10'd5,  1'b0,8'h00,8'h00,1'b1,4'd2},  // R2 mem read
    '{1'b0,1'b1,10'd511,1'b0,8'h00,8'h00,1'b1,4'd2},  // R2 mem write edge
    '{1'b0,1'b0,10'd100,1'b0,8'h00,8'h00,1'b0,4'd2},  // R2 no access
    '{1'b0,1'b0,10'd0,  1'b1,8'h11,8'h00,1'b0,4'd3},  // R3 byte in
    '{1'b1,1'b0,10'd516,1'b1,8'h22,8'h11,1'b0,4'd10}, // R10 collide
    '{1'b1,1'b0,10'd517,1'b0,8'h00,8'h01,1'b0,4'd10}, // R10 ready kept
    '{1'b1,1'b0,10'd516,1'b0,8'h00,8'h22,1'b0,4'd10}, // R10 new byte
    '{1'b0,1'b0,10'd0,  1'b1,8'h44,8'h00,1'b0,4'd3},  // R3 byte in
    '{1'b1,1'b0,10'd517,1'b1,8'h55,8'h01,1'b0,4'd5},  // R5 status, overrun event
    '{1'b1,1'b0,10'd517,1'b0,8'h00,8'h03,1'b0,4'd7},  // R7 set wins
    '{1'b1,1'b0,10'd517,1'b0,8'h00,8'h01,1'b0,4'd7}   // R7 then cleared
  };

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic step(input logic rd, input logic wr, input logic [9:0] a,
                      input logic stb, input logic [7:0] b);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; dev_stb = stb; dev_byte = b;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    step(1'b1, 1'b0, 10'd516, 1'b0, 8'h00);
    check(1, bus_rdata, 8'h00);
    for (int i = 0; i < NV; i++) begin
      step(VT[i].rd, VT[i].wr, VT[i].addr, VT[i].stb, VT[i].dbyte);
      check(int'(VT[i].req), bus_rdata, VT[i].exp_rdata);
      check(2, {7'b0, mem_sel}, {7'b0, VT[i].exp_mem}); // R2
    end
    // R1 mid-run reset discards held byte and flags
    step(1'b0, 1'b0, 10'd0, 1'b1, 8'h9A);
    step(1'b0, 1'b0, 10'd0, 1'b1, 8'h9B);
    step(1'b0, 1'b0, 10'd0, 1'b0, 8'h00);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    step(1'b1, 1'b0, 10'd517, 1'b0, 8'h00);
    check(1, bus_rdata, 8'h00);
    step(1'b1, 1'b0, 10'd516, 1'b0, 8'h00);
    check(1, bus_rdata, 8'h00);
    // R5 upper status bits zero with both flags set
    step(1'b0, 1'b0, 10'd0, 1'b1, 8'hFF);
    step(1'b0, 1'b0, 10'd0, 1'b1, 8'hFE);
    step(1'b1, 1'b0, 10'd517, 1'b0, 8'h00);
    check(5, bus_rdata, 8'h03);
    step(1'b0, 1'b0, 10'd0, 1'b0, 8'h00);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule